// File: doc/BRIEF.md
# SDRAM Mode Word and Read Latency Timer

This block is the timing core on the command side of an SDRAM controller. It keeps the mode word the controller last loaded. From that word it reports the burst length that applies to the access being issued. For every READ command it produces two signals at the programmed column latency: a device-drive indication and a data-valid strobe with the captured read data.

A mode load is checked before it is applied. A word that asks for a latency other than 2 or 3, for the unsupported interleaved beat order, or for a reserved operating mode is refused, and the previous settings stay in force. A reserved operating mode also raises a flag. Reads that follow one another while an earlier burst is still in flight are tracked in a shift schedule, so each burst keeps its own window and the data order is preserved.

Top module: `sdram_rdlat_core`

## Requirements
- R1: After reset the settings are burst length 1, latency 3, bursting writes and normal mode. `illegal_mode` is 0, and `dq_drive` and `rd_valid` stay 0 until a READ is registered.
- R2: Mode bits 2:0 select the burst length. Codes 0, 1, 2 and 3 give 1, 2, 4 and 8 beats, and codes 4 to 7 give 8 beats. When no single-location write is being issued, `burst_len` shows this length.
- R3: While mode bit 9 is 0, `burst_len` during a WRITE equals the programmed length. While bit 9 is 1, `burst_len` is 1 during a WRITE, and READs still use the programmed length.
- R4: Mode bits 6:4 hold the latency. A load is applied only if that field is 2 or 3, bit 3 is 0 and bits 8:7 are 00. Any other load leaves burst length, latency and write mode unchanged.
- R5: On every load, `illegal_mode` becomes 1 if bits 8:7 of the loaded word are not 00, and becomes 0 otherwise. It holds that value until the next load.
- R6: For a READ registered at clock edge n with latency m and burst length L, `dq_drive` is 1 after edges n+m-1 through n+m+L-2, one cycle ahead of valid data.
- R7: `rd_valid` is 1 after edges n+m through n+m+L-1. After each of those edges, `rd_data` holds the value that was on `dq_in` at that edge.
- R8: A READ registered L or more cycles after the previous READ gets its own complete window. With a spacing of exactly L the two windows join into one unbroken run of valid beats, and the data stays in order.
- R9: WRITE commands, mode loads and idle cycles never assert `dq_drive` or `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lmr | input | 1 | Load-mode command strobe |
| mode_in | input | 10 | Mode word offered with `lmr` |
| rd_cmd | input | 1 | READ command strobe |
| wr_cmd | input | 1 | WRITE command strobe |
| dq_in | input | DATA_W | Read data from the device |
| burst_len | output | 4 | Beats in the access being issued |
| dq_drive | output | 1 | Device drives data on the next edge |
| rd_valid | output | 1 | `rd_data` holds a fresh beat |
| rd_data | output | DATA_W | Captured read beat |
| illegal_mode | output | 1 | Last load requested a reserved operating mode |

## Verification
The hardest case to reach is a READ issued exactly one burst length after the previous one. At that spacing the tail of the first window meets the head of the second in the schedule, and any off-by-one error shows up as a gap or a duplicated beat. The stimulus steers reads to the earliest legal cycle in a directed sequence with burst length 4 and latency 2. The random phase then often picks that same earliest cycle under mixed lengths and latencies. Rejected loads are mixed in between, so a later read shows whether the old timing survived.

// File: rtl/sdram_tim_pkg.sv
package sdram_tim_pkg;

    localparam int MODE_W   = 10;
    localparam int MAX_BL   = 8;
    localparam int BL_W     = 4;
    localparam int MAX_LAT  = 3;
    localparam int SCHED_D  = MAX_LAT + MAX_BL;

    // field positions in the loaded word
    localparam int F_BL_LO   = 0;
    localparam int F_ORDER   = 3;
    localparam int F_LAT_LO  = 4;
    localparam int F_OPM_LO  = 7;
    localparam int F_WSINGLE = 9;

    typedef struct packed {
        logic [2:0] bl_code;
        logic       wr_single;
        logic [1:0] lat;
    } mode_cfg_t;

    localparam mode_cfg_t CFG_RESET = '{bl_code: 3'd0, wr_single: 1'b0, lat: 2'd3};

    function automatic logic [BL_W-1:0] bl_decode(input logic [2:0] code);
        logic [BL_W-1:0] r;
        if (code[2]) r = BL_W'(MAX_BL);
        else         r = BL_W'(1) << code[1:0];
        return r;
    endfunction

    function automatic logic lat_ok(input logic [2:0] f);
        return (f == 3'd2) || (f == 3'd3);
    endfunction

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
    import sdram_tim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [MODE_W-1:0] word,
    output mode_cfg_t         cfg,
    output logic              illegal
);
    logic [2:0] lat_f;
    logic [1:0] opm_f;
    logic       accept;

    always_comb begin
        lat_f  = word[F_LAT_LO +: 3];
        opm_f  = word[F_OPM_LO +: 2];
        accept = lat_ok(lat_f) && (opm_f == 2'b00) && !word[F_ORDER];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= CFG_RESET;
            illegal <= 1'b0;
        end else if (load) begin
            illegal <= (opm_f != 2'b00);
            if (accept) begin
                cfg.bl_code   <= word[F_BL_LO +: 3];
                cfg.wr_single <= word[F_WSINGLE];
                cfg.lat       <= lat_f[1:0];
            end
        end
    end

    // R4
    lat_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !lat_ok(word[F_LAT_LO +: 3])) |=> $stable(cfg));

    // R5
    reserved_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (load && (word[F_OPM_LO +: 2] != 2'b00)) |=> (illegal && $stable(cfg)));

    // R4
    lat_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.lat == 2'd2) || (cfg.lat == 2'd3));

endmodule

// File: rtl/sdram_beat_sched.sv
module sdram_beat_sched
    import sdram_tim_pkg::*;
#(
    parameter int DEPTH = SCHED_D
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [1:0]      lat,
    input  logic [BL_W-1:0] len,
    output logic            drive
);
    logic [DEPTH-1:0] sched;
    logic [DEPTH-1:0] mask;

    // slot j set means the device drives j edges after this one
    for (genvar j = 0; j < DEPTH; j++) begin : g_slot
        assign mask[j] = (j >= int'(lat) - 1) && (j < int'(lat) - 1 + int'(len));
    end

    always_ff @(posedge clk) begin
        if (rst) sched <= '0;
        else     sched <= {1'b0, sched[DEPTH-1:1]} | (start ? mask : '0);
    end

    assign drive = sched[0];

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] dq_in,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= take;
            if (take) data <= dq_in;
        end
    end
endmodule

// File: rtl/sdram_rdlat_core.sv
module sdram_rdlat_core
    import sdram_tim_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lmr,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              rd_cmd,
    input  logic              wr_cmd,
    input  logic [DATA_W-1:0] dq_in,
    output logic [BL_W-1:0]   burst_len,
    output logic              dq_drive,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              illegal_mode
);
    mode_cfg_t       cfg;
    logic [BL_W-1:0] rd_len;

    sdram_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .load    (lmr),
        .word    (mode_in),
        .cfg     (cfg),
        .illegal (illegal_mode)
    );

    assign rd_len    = bl_decode(cfg.bl_code);
    assign burst_len = (wr_cmd && cfg.wr_single) ? BL_W'(1) : rd_len;

    sdram_beat_sched #(.DEPTH(SCHED_D)) u_sched (
        .clk   (clk),
        .rst   (rst),
        .start (rd_cmd),
        .lat   (cfg.lat),
        .len   (rd_len),
        .drive (dq_drive)
    );

    sdram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .take  (dq_drive),
        .dq_in (dq_in),
        .valid (rd_valid),
        .data  (rd_data)
    );

    // R6
    drv_lat2_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_cmd && cfg.lat == 2'd2) |=> ##1 dq_drive);

    // R6
    drv_lat3_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_cmd && cfg.lat == 2'd3) |=> ##2 dq_drive);

    // R7
    valid_after_drive_chk: assert property (@(posedge clk) disable iff (rst)
        dq_drive |=> rd_valid);

    // R9
    no_stray_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !dq_drive |=> !rd_valid);

endmodule

// File: tb/sdram_rdlat_core_test.sv
module sdram_rdlat_core_test;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lmr = 1'b0;
    logic [9:0]    mode_in = '0;
    logic          rd_cmd = 1'b0;
    logic          wr_cmd = 1'b0;
    logic [DW-1:0] dq_in = '0;
    logic [3:0]    burst_len;
    logic          dq_drive, rd_valid, illegal_mode;
    logic [DW-1:0] rd_data;

    sdram_rdlat_core #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .lmr(lmr), .mode_in(mode_in),
        .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .dq_in(dq_in),
        .burst_len(burst_len), .dq_drive(dq_drive), .rd_valid(rd_valid),
        .rd_data(rd_data), .illegal_mode(illegal_mode)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad = 0;
    bit exp_drv [0:255];
    bit exp_val [0:255];

    // model of the settings in force
    int m_code = 0;
    int m_ws   = 0;
    int m_lat  = 3;
    int m_ill  = 0;
    int last_end = -1;
    int next_rd  = 0;

    function automatic int bl_of(input int code);
        if (code >= 4) return 8;
        return 1 << code;
    endfunction

    function automatic logic [DW-1:0] beat(input int e);
        logic [31:0] h;
        h = (e * 32'h9E3779B1) ^ 32'h5A5A1234;
        return h[31:16];
    endfunction

    task automatic chk(input int act, input int expv, input string tag);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, expv, cyc);
        end
    endtask

    task automatic step(input bit ld, input logic [9:0] w, input bit rd, input bit wr);
        int e, n, bl;
        @(negedge clk);
        e = cyc;
        chk(int'(dq_drive), int'(exp_drv[e % 256]), "R6 R9 drive");
        chk(int'(rd_valid), int'(exp_val[e % 256]), "R7 R8 valid");
        if (exp_val[e % 256]) chk(int'(rd_data), int'(beat(e - 1)), "R7 R8 data");
        chk(int'(illegal_mode), m_ill, "R5 flag");
        exp_drv[e % 256] = 1'b0;
        exp_val[e % 256] = 1'b0;
        dq_in   = beat(e);
        lmr     = ld;
        mode_in = w;
        rd_cmd  = rd;
        wr_cmd  = wr;
        #1;
        chk(int'(burst_len), (wr && m_ws != 0) ? 1 : bl_of(m_code), "R2 R3 R4 burst_len");
        if (rd) begin
            n  = e + 1;
            bl = bl_of(m_code);
            for (int k = 0; k < bl; k++) begin
                exp_drv[(n + m_lat - 1 + k) % 256] = 1'b1;
                exp_val[(n + m_lat + k) % 256]     = 1'b1;
            end
            last_end = n + m_lat + bl - 1;
            next_rd  = n + bl;
        end
        if (ld) begin
            m_ill = (w[8:7] != 2'b00) ? 1 : 0;
            if (w[8:7] == 2'b00 && !w[3] && (w[6:4] == 3'd2 || w[6:4] == 3'd3)) begin
                m_code = int'(w[2:0]);
                m_ws   = int'(w[9]);
                m_lat  = int'(w[6:4]);
            end
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(1'b0, '0, 1'b0, 1'b0);
    endtask

    function automatic logic [9:0] mkword(input int ws, input int opm, input int lat,
                                          input int ord, input int code);
        return {1'(ws), 2'(opm), 3'(lat), 1'(ord), 3'(code)};
    endfunction

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int r;
        int e;
        logic [9:0] w;
        for (int i = 0; i < 256; i++) begin
            exp_drv[i] = 1'b0;
            exp_val[i] = 1'b0;
        end
        r = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(int'(burst_len), 1, "R1 burst_len");
        chk(int'(illegal_mode), 0, "R1 illegal_mode");
        chk(int'(dq_drive), 0, "R1 dq_drive");
        chk(int'(rd_valid), 0, "R1 rd_valid");
        idle(3);
        // R1 default read: one beat at latency 3
        step(1'b0, '0, 1'b1, 1'b0);
        idle(6);
        // R2 R8: length 4, latency 2, back-to-back at exact spacing
        step(1'b1, mkword(0, 0, 2, 0, 2), 1'b0, 1'b0);
        step(1'b0, '0, 1'b1, 1'b0);
        idle(3);
        step(1'b0, '0, 1'b1, 1'b0);
        idle(3);
        step(1'b0, '0, 1'b1, 1'b0);
        idle(10);
        // R4 rejected latency keeps length 4
        step(1'b1, mkword(1, 0, 5, 0, 3), 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b1);
        chk(int'(burst_len), 4, "R4 kept length");
        step(1'b0, '0, 1'b1, 1'b0);
        idle(8);
        // R5 reserved op mode flagged and refused
        step(1'b1, mkword(0, 1, 3, 0, 0), 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b0);
        chk(int'(illegal_mode), 1, "R5 set");
        chk(int'(burst_len), 4, "R5 refused");
        // R3 single-location writes
        step(1'b1, mkword(1, 0, 3, 0, 3), 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b1);
        chk(int'(burst_len), 1, "R3 write single");
        chk(int'(illegal_mode), 0, "R5 cleared");
        step(1'b0, '0, 1'b1, 1'b0);
        chk(int'(burst_len), 8, "R3 read keeps length");
        idle(14);
        // random phase
        for (int i = 0; i < 3000; i++) begin
            r = int'($urandom % 8);
            e = cyc;
            if (r == 0 && e + 1 > last_end) begin
                w = mkword(int'($urandom % 2),
                           ($urandom % 4 == 0) ? int'($urandom % 4) : 0,
                           ($urandom % 3 == 0) ? int'($urandom % 8) : 2 + int'($urandom % 2),
                           ($urandom % 8 == 0) ? 1 : 0,
                           int'($urandom % 8));
                step(1'b1, w, 1'b0, 1'b0);
            end else if (r >= 1 && r <= 3 && e + 1 >= next_rd) begin
                step(1'b0, '0, 1'b1, 1'b0);
            end else if (r == 4) begin
                step(1'b0, '0, 1'b0, 1'b1);
            end else begin
                idle(1);
            end
        end
        idle(20);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule